// File: doc/BRIEF.md
# Clock Chip Validity Check Initialiser

This block runs once after reset. It decides whether the time held in an external clock chip can be trusted, and it recovers the chip when the chip reports that its oscillator stopped. It does not drive the serial wires itself. Each register access goes to a register access master through a request/acknowledge port. The only pins it drives directly are the chip enable and a line-parking strobe.

After a power-cycle of the chip enable, the block reads the chip's control register. If the oscillator-stop flag is clear, it reports the time as valid and finishes. If the flag is set, the block does the following in order:

1. It reports the time as invalid.
2. It clears the timer interrupt register.
3. It writes the control register with the base value plus the adjust bit.
4. It polls the busy flag, leaving a gap between polls and stopping after a bounded number of tries.
5. If busy clears, it writes the base value back. If the try limit runs out, it raises an error instead.

Every path ends with chip enable low and a sticky done flag. Register addresses, the base value, the bit positions, the wait lengths and the try limit are all parameters.

Top module: `clkchip_validity_init`

## Requirements
- R1: After reset, chip enable is low for SETTLE_CYC cycles. Then `line_park` is high with chip enable low for PARK_CYC cycles. Then chip enable is high for SETTLE_CYC cycles before a read of address CTRL_ADDR is requested.
- R2: If bit STOP_BIT of that first read is 0, `time_valid` becomes 1 in the acknowledge cycle, and no write is issued.
- R3: If bit STOP_BIT is 1, `time_valid` stays 0. The block then writes 0 to TINT_ADDR, followed by CTRL_BASE with bit ADJ_BIT set to CTRL_ADDR.
- R4: After that write, CTRL_ADDR is read repeatedly with bit BUSY_BIT tested. There are exactly POLL_GAP_CYC idle cycles between polls and at most MAX_TRIES reads.
- R5: If bit BUSY_BIT is 1 on the MAX_TRIES-th poll, `init_error` becomes 1 and no further write is issued.
- R6: If a poll returns bit BUSY_BIT as 0, CTRL_BASE alone is written to CTRL_ADDR and `init_error` stays 0.
- R7: On every path, chip enable is low for SETTLE_CYC cycles before `init_done` rises. `init_done`, `time_valid` and `init_error` then hold their values until reset.
- R8: A request holds its address, direction and write data steady until acknowledged, and chip enable is high whenever a request is raised.
- R9: `time_valid` and `init_error` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | output | 1 | Register access request |
| acc_write | output | 1 | 1 = write, 0 = read |
| acc_addr | output | ADDR_W | Register address |
| acc_wdata | output | DATA_W | Write data (0 for reads) |
| acc_ack | input | 1 | One-cycle completion pulse from the access master |
| acc_rdata | input | DATA_W | Read data, valid with `acc_ack` |
| chip_en | output | 1 | Chip enable to the clock chip |
| line_park | output | 1 | Strobe asking the master to park the serial lines |
| time_valid | output | 1 | Chip time judged valid |
| init_done | output | 1 | Sequence finished (sticky) |
| init_error | output | 1 | Busy flag never cleared |

## Verification
The assertions assume the access master raises `acc_ack` only while `acc_req` is high, and only as a single-cycle pulse with `acc_rdata` valid in that cycle. The bench's master model enforces this. It counts a fixed latency of negedges with the request high, pulses the acknowledge once, and then drops it for at least one cycle before serving the next request. It serves only control-register reads with meaningful data, sets an unrelated high data bit to show that only the tested bits matter, and reports busy for a chosen number of polls.

// File: rtl/cvi_pkg.sv
package cvi_pkg;

    typedef enum logic [3:0] {
        ST_START,
        ST_CE_OFF,
        ST_PARK,
        ST_CE_ON,
        ST_RD_CTRL,
        ST_WR_TINT,
        ST_WR_ADJ,
        ST_POLL,
        ST_GAP,
        ST_WR_BASE,
        ST_CE_REL,
        ST_FIN
    } cvi_state_e;

    typedef struct packed {
        cvi_state_e state;
        logic       valid;
        logic       err;
    } cvi_regs_t;

endpackage

// File: rtl/cvi_countdown.sv
module cvi_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cvi_try_counter.sv
module cvi_try_counter #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));

    // R4: a further busy poll is never scheduled once the limit is reached
    a_r4_no_extra_try: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt_q < CW'(LIMIT - 1)));
endmodule

// File: rtl/clkchip_validity_init.sv
module clkchip_validity_init
    import cvi_pkg::*;
#(
    parameter int          DATA_W       = 4,
    parameter int          ADDR_W       = 4,
    parameter logic [3:0]  CTRL_ADDR    = 4'hF,
    parameter logic [3:0]  TINT_ADDR    = 4'hE,
    parameter logic [3:0]  CTRL_BASE    = 4'h2,
    parameter int          STOP_BIT     = 2,
    parameter int          ADJ_BIT      = 0,
    parameter int          BUSY_BIT     = 0,
    parameter int          SETTLE_CYC   = 30000,
    parameter int          PARK_CYC     = 5000,
    parameter int          POLL_GAP_CYC = 50,
    parameter int          MAX_TRIES    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              acc_req,
    output logic              acc_write,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_ack,
    input  logic [DATA_W-1:0] acc_rdata,
    output logic              chip_en,
    output logic              line_park,
    output logic              time_valid,
    output logic              init_done,
    output logic              init_error
);
    localparam int T_MAX1 = (SETTLE_CYC > PARK_CYC) ? SETTLE_CYC : PARK_CYC;
    localparam int T_MAX  = (T_MAX1 > POLL_GAP_CYC) ? T_MAX1 : POLL_GAP_CYC;
    localparam int TW     = $clog2(T_MAX + 1);
    localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] LD_PARK   = TW'(PARK_CYC - 1);
    localparam logic [TW-1:0] LD_GAP    = TW'(POLL_GAP_CYC - 1);
    localparam logic [DATA_W-1:0] W_BASE = DATA_W'(CTRL_BASE);
    localparam logic [DATA_W-1:0] W_ADJ  = W_BASE | (DATA_W'(1) << ADJ_BIT);

    cvi_regs_t r_d, r_q;
    logic          tmr_load, tmr_zero, try_clr, try_inc, try_last;
    logic [TW-1:0] tmr_val;

    cvi_countdown #(.W(TW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_zero)
    );

    cvi_try_counter #(.LIMIT(MAX_TRIES)) u_tries (
        .clk(clk), .rst_n(rst_n), .clr(try_clr),
        .inc(try_inc), .last(try_last)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = LD_SETTLE;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        unique case (r_q.state)
            ST_START: begin
                tmr_load  = 1'b1;
                r_d.state = ST_CE_OFF;
            end
            ST_CE_OFF: if (tmr_zero) begin
                tmr_load  = 1'b1;
                tmr_val   = LD_PARK;
                r_d.state = ST_PARK;
            end
            ST_PARK: if (tmr_zero) begin
                tmr_load  = 1'b1;
                r_d.state = ST_CE_ON;
            end
            ST_CE_ON: if (tmr_zero) r_d.state = ST_RD_CTRL;
            ST_RD_CTRL: if (acc_ack) begin
                if (acc_rdata[STOP_BIT]) begin
                    r_d.state = ST_WR_TINT;
                end else begin
                    r_d.valid = 1'b1;
                    tmr_load  = 1'b1;
                    r_d.state = ST_CE_REL;
                end
            end
            ST_WR_TINT: if (acc_ack) r_d.state = ST_WR_ADJ;
            ST_WR_ADJ: if (acc_ack) begin
                try_clr   = 1'b1;
                r_d.state = ST_POLL;
            end
            ST_POLL: if (acc_ack) begin
                if (!acc_rdata[BUSY_BIT]) begin
                    r_d.state = ST_WR_BASE;
                end else if (try_last) begin
                    r_d.err   = 1'b1;
                    tmr_load  = 1'b1;
                    r_d.state = ST_CE_REL;
                end else begin
                    try_inc   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_GAP;
                    r_d.state = ST_GAP;
                end
            end
            ST_GAP: if (tmr_zero) r_d.state = ST_POLL;
            ST_WR_BASE: if (acc_ack) begin
                tmr_load  = 1'b1;
                r_d.state = ST_CE_REL;
            end
            ST_CE_REL: if (tmr_zero) r_d.state = ST_FIN;
            default: r_d.state = ST_FIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_START, valid: 1'b0, err: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        acc_req   = 1'b0;
        acc_write = 1'b0;
        acc_addr  = ADDR_W'(CTRL_ADDR);
        acc_wdata = '0;
        unique case (r_q.state)
            ST_RD_CTRL, ST_POLL: acc_req = 1'b1;
            ST_WR_TINT: begin
                acc_req   = 1'b1;
                acc_write = 1'b1;
                acc_addr  = ADDR_W'(TINT_ADDR);
            end
            ST_WR_ADJ: begin
                acc_req   = 1'b1;
                acc_write = 1'b1;
                acc_wdata = W_ADJ;
            end
            ST_WR_BASE: begin
                acc_req   = 1'b1;
                acc_write = 1'b1;
                acc_wdata = W_BASE;
            end
            default: ;
        endcase
    end

    assign chip_en    = (r_q.state inside {ST_CE_ON, ST_RD_CTRL, ST_WR_TINT, ST_WR_ADJ,
                                           ST_POLL, ST_GAP, ST_WR_BASE});
    assign line_park  = (r_q.state == ST_PARK);
    assign init_done  = (r_q.state == ST_FIN);
    assign time_valid = r_q.valid;
    assign init_error = r_q.err;

    a_r1_park_with_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        line_park |-> !chip_en);
    a_r5_no_write_after_error: assert property (@(posedge clk) disable iff (!rst_n)
        init_error |-> !(acc_req && acc_write));
    a_r7_done_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!chip_en && !acc_req));
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && $stable(time_valid) && $stable(init_error)));
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_ack) |=> (acc_req && $stable(acc_addr) &&
                                   $stable(acc_write) && $stable(acc_wdata)));
    a_r8_ce_during_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> chip_en);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(time_valid && init_error));
endmodule

// File: tb/tb_clkchip_validity_init.sv
module tb_clkchip_validity_init;
    localparam int SET = 3, PRK = 4, GAP = 5, TRIES = 6;
    localparam logic [3:0] CA = 4'hF, TA = 4'hE, BASE = 4'h2;
    localparam logic [3:0] ADJV = 4'h3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_req, acc_write, acc_ack, chip_en, line_park, time_valid, init_done, init_error;
    logic [3:0] acc_addr, acc_wdata, acc_rdata;

    always #10 clk = ~clk;

    clkchip_validity_init #(
        .CTRL_ADDR(CA), .TINT_ADDR(TA), .CTRL_BASE(BASE), .STOP_BIT(2), .ADJ_BIT(0),
        .BUSY_BIT(0), .SETTLE_CYC(SET), .PARK_CYC(PRK), .POLL_GAP_CYC(GAP), .MAX_TRIES(TRIES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
        .acc_rdata(acc_rdata), .chip_en(chip_en), .line_park(line_park),
        .time_valid(time_valid), .init_done(init_done), .init_error(init_error)
    );

    int checks = 0, errors = 0;
    int lat = 3, busy_polls = 0, poll_seen = 0;
    bit osc_stop = 0, adj_seen = 0, cmp_en = 0;
    logic [7:0] act_log[$], exp_log[$];

    // expected port values
    string e_tag = "R1";
    bit e_ce, e_park, e_req, e_we, e_valid, e_err, e_done;
    logic [3:0] e_addr, e_wd;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // access master model
    initial begin
        int cnt = 0;
        acc_ack = 1'b0;
        acc_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                acc_ack = 1'b0; cnt = 0;
            end else if (acc_ack) begin
                acc_ack = 1'b0; cnt = 0;
            end else if (acc_req) begin
                cnt++;
                if (cnt >= lat) begin
                    acc_ack = 1'b1;
                    if (acc_write) begin
                        act_log.push_back({acc_addr, acc_wdata});
                        if (acc_addr == CA && acc_wdata == ADJV) adj_seen = 1;
                        acc_rdata = '0;
                    end else if (acc_addr == CA) begin
                        if (!adj_seen) acc_rdata = (osc_stop ? 4'h4 : 4'h0) | 4'h8;
                        else begin
                            acc_rdata = ((poll_seen < busy_polls) ? 4'h1 : 4'h0) | 4'h8;
                            poll_seen++;
                        end
                    end else acc_rdata = 4'h0;
                end
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) if (cmp_en) begin
        chk(e_tag, "chip_en", chip_en, e_ce);
        chk("R1", "line_park", line_park, e_park);
        chk("R8", "acc_req", acc_req, e_req);
        if (e_req) begin
            chk(e_tag, "acc_write", acc_write, e_we);
            chk(e_tag, "acc_addr", acc_addr, e_addr);
            if (e_we) chk(e_tag, "acc_wdata", acc_wdata, e_wd);
        end
        chk("R2", "time_valid", time_valid, e_valid);
        chk("R5", "init_error", init_error, e_err);
        chk("R7", "init_done", init_done, e_done);
    end

    task automatic put(input string t, input bit ce, input bit pk, input bit rq,
                       input bit we, input logic [3:0] a, input logic [3:0] d);
        e_tag = t; e_ce = ce; e_park = pk; e_req = rq; e_we = we; e_addr = a; e_wd = d;
    endtask

    task automatic stay(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_ack;
        do @(posedge clk); while (!acc_ack);
    endtask

    task automatic scenario(input bit stop, input int busy, input int l, input string name);
        int polls = 0;
        @(negedge clk);
        cmp_en = 0; rst_n = 0;
        osc_stop = stop; busy_polls = busy; lat = l; poll_seen = 0; adj_seen = 0;
        act_log.delete(); exp_log.delete();
        e_valid = 0; e_err = 0; e_done = 0;
        put("R1", 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        cmp_en = 1;                       // R1: reset state checked here
        @(negedge clk);
        rst_n = 1;
        stay(1);
        put("R1", 0, 0, 0, 0, 0, 0); stay(SET);
        put("R1", 0, 1, 0, 0, 0, 0); stay(PRK);
        put("R1", 1, 0, 0, 0, 0, 0); stay(SET);
        put("R1", 1, 0, 1, 0, CA, 0); wait_ack;
        if (!stop) e_valid = 1;          // R2
        else begin
            put("R3", 1, 0, 1, 1, TA, 4'h0); exp_log.push_back({TA, 4'h0}); wait_ack;
            put("R3", 1, 0, 1, 1, CA, ADJV); exp_log.push_back({CA, ADJV}); wait_ack;
            for (int k = 0; ; k++) begin
                put("R4", 1, 0, 1, 0, CA, 0); wait_ack;
                polls++;
                if (k >= busy) begin
                    put("R6", 1, 0, 1, 1, CA, BASE); exp_log.push_back({CA, BASE}); wait_ack;
                    break;
                end
                if (k == TRIES - 1) begin e_err = 1; break; end   // R5
                put("R4", 1, 0, 0, 0, 0, 0); stay(GAP);
            end
        end
        put("R7", 0, 0, 0, 0, 0, 0); stay(SET);
        e_done = 1; stay(6);
        @(negedge clk);
        cmp_en = 0;
        chk(stop ? "R3" : "R2", {name, " write count"}, act_log.size(), exp_log.size());
        for (int i = 0; i < exp_log.size() && i < act_log.size(); i++)
            chk(stop ? "R6" : "R2", {name, " write entry"}, act_log[i], exp_log[i]);
        chk("R4", {name, " poll count"}, poll_seen, polls);
        chk("R9", {name, " valid/error exclusive"}, int'(time_valid && init_error), 0);
    endtask

    initial begin
        scenario(0, 0, 3, "clean");
        scenario(1, 0, 1, "busy-none");
        scenario(1, 2, 3, "busy-two");
        scenario(1, TRIES - 1, 2, "busy-last-try");
        scenario(1, 99, 3, "busy-stuck");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule